// File: doc/BRIEF.md
# Paired Rail Step Pattern Generator

This block produces the digital control pattern for a set of RC-shaped step rails. Each control line toggles a complementary pair of rails between their SET and RESET levels. One rail of the pair swings positive and the other swings negative, at the same instant. With the default parameters there are 24 control lines, which serve 48 rails. The lines are held in three byte-wide output registers. The block fills these registers one byte at a time over a small write bus. It then transfers all three together with a single load pulse, so every line changes in the same cycle.

A run begins with a `start` pulse that captures a 16-bit warm-up count. Each pulse on the external step enable moves the run forward by one pattern step. During warm-up only the forward-pipeline patterns are produced, so that the pipeline can fill. Once the requested number of warm-up steps have loaded, the block switches to full operation, where each step drives a forward line together with its mirrored reverse line. The status output `full_op` reports which of the two phases is active. Within each pattern set the step index wraps back to the first entry.

Top module: `rail_step_seq`

## Requirements
- R1: While reset is held and after it is released, `rail_lines`, `running`, `full_op`, `reg_wr` and `reg_load` are 0, and `reg_sel` and `reg_data` are 0.
- R2: Before the first `start` after reset, `step_en` has no effect: no write and no load appear, and `rail_lines` stays 0.
- R3: A step enable accepted in an idle running cycle captures the current pattern word. In the three following cycles `reg_wr` is 1 with `reg_sel` equal to 0, 1 and 2 in turn, and `reg_data` equal to word bits [7:0], [15:8] and [23:16]. `reg_sel` and `reg_data` are 0 whenever `reg_wr` is 0.
- R4: `reg_load` is high for exactly the one cycle that follows the write of byte 2. All 24 bits of `rail_lines` take the captured word in the cycle after that, and they change at no other time.
- R5: A `step_en` seen in any write or load cycle is ignored. A new step is accepted only in a cycle with no write and no load in progress.
- R6: In warm-up, step k (k from 0 to 11) drives line k alone to 1.
- R7: In full operation, step k drives line k and line 23−k to 1 and all other lines to 0.
- R8: Warm-up lasts for the first W loads after `start`, where W is `warmup_cycles` sampled at `start`. `full_op` rises in the cycle after the W-th load. If W is 0, `full_op` is 1 from the cycle after `start`. `full_op` stays 1 until the next `start` or reset.
- R9: The step index runs 0 to 11 and then wraps to 0 in both sets. Entering full operation restarts the index at 0.
- R10: `start` clears the index and the warm-up count and abandons any write sequence that has not yet loaded. A load that falls in the same cycle as `start` still updates `rail_lines`, and lines that were already loaded keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart a run and capture the warm-up count |
| step_en | input | 1 | External request to advance one pattern step |
| warmup_cycles | input | 16 | Number of forward-only steps before full operation |
| reg_sel | output | 2 | Byte register select for the current write |
| reg_data | output | 8 | Byte written to the selected register |
| reg_wr | output | 1 | Write strobe for a staging byte |
| reg_load | output | 1 | Common transfer pulse from staging to outputs |
| rail_lines | output | 24 | Switch-control lines, one per complementary rail pair |
| running | output | 1 | A run is in progress |
| full_op | output | 1 | 1 in full operation, 0 in warm-up or when idle |

## Verification
Two events can fall in the same cycle. The load that completes the last warm-up step is also the event that switches the pattern set and resets the index, and a step enable can arrive during that load, or a `start` can arrive with it. The bench holds `step_en` high for long stretches and also gives it a pseudo-random pattern, so that requests land on write and load cycles, including the load that ends warm-up. It also pulses `start` at several points inside a write sequence. A behavioural queue model predicts the write bus, load pulse, lines and status in every cycle, and a dropped request or a pattern from the wrong set or index shows up as a miscompare on the next word.

// File: rtl/rail_step_pkg.sv
package rail_step_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_WAIT  = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_LOAD  = 2'd3
   } seq_state_t;

endpackage

// File: rtl/rail_pat_rom.sv
module rail_pat_rom #(
   parameter int LINES = 24,
   parameter int STEPS = LINES / 2,
   parameter int IDX_W = $clog2(STEPS)
) (
   input  logic             full_set,
   input  logic [IDX_W-1:0] idx,
   output logic [LINES-1:0] word
);

   logic [LINES-1:0] fwd_tab  [STEPS];
   logic [LINES-1:0] full_tab [STEPS];

   generate
      if (STEPS * 2 > LINES) begin : g_bad_steps
         $error("rail_pat_rom: STEPS must not exceed half of LINES");
      end
      for (genvar k = 0; k < STEPS; k++) begin : g_entry
         assign fwd_tab[k]  = LINES'(1) << k;
         assign full_tab[k] = (LINES'(1) << k) | (LINES'(1) << (LINES - 1 - k));
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int k = 0; k < STEPS; k++) begin
         if (idx == IDX_W'(k)) begin
            word = full_set ? full_tab[k] : fwd_tab[k];
         end
      end
   end

endmodule

// File: rtl/rail_warmup_ctr.sv
module rail_warmup_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] target,
   input  logic             step_done,
   output logic             full_op,
   output logic             enter_full
);

   logic [CNT_W-1:0] done_cnt;
   logic [CNT_W-1:0] tgt_q;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rail_warmup_ctr: CNT_W must be at least 1");
      end
   endgenerate

   assign enter_full = step_done && !full_op && !start && (done_cnt + CNT_W'(1) == tgt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_cnt <= '0;
         tgt_q    <= '0;
         full_op  <= 1'b0;
      end else if (start) begin
         done_cnt <= '0;
         tgt_q    <= target;
         full_op  <= (target == '0);
      end else if (step_done && !full_op) begin
         done_cnt <= done_cnt + CNT_W'(1);
         if (enter_full) begin
            full_op <= 1'b1;
         end
      end
   end

   assert_full_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (full_op && !start) |=> full_op);

   assert_full_rise_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!full_op && !start && !step_done) |=> !full_op);

endmodule

// File: rtl/rail_byte_bank.sv
module rail_byte_bank #(
   parameter int NUM_BYTES = 3,
   parameter int BYTE_W    = 8,
   parameter int SEL_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [SEL_W-1:0]            sel,
   input  logic [BYTE_W-1:0]           data,
   input  logic                        load,
   output logic [NUM_BYTES*BYTE_W-1:0] lines
);

   logic [NUM_BYTES*BYTE_W-1:0] staging;

   generate
      if ((1 << SEL_W) < NUM_BYTES) begin : g_bad_sel
         $error("rail_byte_bank: SEL_W too narrow for NUM_BYTES");
      end
      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               staging[b*BYTE_W +: BYTE_W] <= '0;
               lines[b*BYTE_W +: BYTE_W]   <= '0;
            end else begin
               if (wr && sel == SEL_W'(b)) begin
                  staging[b*BYTE_W +: BYTE_W] <= data;
               end
               if (load) begin
                  lines[b*BYTE_W +: BYTE_W] <= staging[b*BYTE_W +: BYTE_W];
               end
            end
         end
      end
   endgenerate

   assert_lines_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(lines));

endmodule

// File: rtl/rail_step_seq.sv
module rail_step_seq
   import rail_step_pkg::*;
#(
   parameter int NUM_BYTES = 3,
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 16,
   parameter int SEL_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        step_en,
   input  logic [CNT_W-1:0]            warmup_cycles,
   output logic [SEL_W-1:0]            reg_sel,
   output logic [BYTE_W-1:0]           reg_data,
   output logic                        reg_wr,
   output logic                        reg_load,
   output logic [NUM_BYTES*BYTE_W-1:0] rail_lines,
   output logic                        running,
   output logic                        full_op
);

   localparam int LINES = NUM_BYTES * BYTE_W;
   localparam int STEPS = LINES / 2;
   localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   generate
      if (LINES % 2 != 0) begin : g_bad_pairs
         $error("rail_step_seq: line count must be even");
      end
      if ((1 << SEL_W) < NUM_BYTES) begin : g_bad_sel
         $error("rail_step_seq: SEL_W too narrow");
      end
   endgenerate

   seq_state_t       st;
   logic [SEL_W-1:0] bidx;
   logic [IDX_W-1:0] idx;
   logic [LINES-1:0] word_q;
   logic [LINES-1:0] rom_word;
   logic             enter_full;
   logic             step_done;

   rail_pat_rom #(
      .LINES (LINES),
      .STEPS (STEPS),
      .IDX_W (IDX_W)
   ) u_rom (
      .full_set (full_op),
      .idx      (idx),
      .word     (rom_word)
   );

   assign step_done = (st == SQ_LOAD);

   rail_warmup_ctr #(
      .CNT_W (CNT_W)
   ) u_warm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .target     (warmup_cycles),
      .step_done  (step_done),
      .full_op    (full_op),
      .enter_full (enter_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         bidx   <= '0;
         idx    <= '0;
         word_q <= '0;
      end else if (start) begin
         st   <= SQ_WAIT;
         bidx <= '0;
         idx  <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: ;
            SQ_WAIT: begin
               if (step_en) begin
                  word_q <= rom_word;
                  bidx   <= '0;
                  st     <= SQ_WRITE;
               end
            end
            SQ_WRITE: begin
               if (bidx == SEL_W'(NUM_BYTES - 1)) begin
                  st <= SQ_LOAD;
               end else begin
                  bidx <= bidx + SEL_W'(1);
               end
            end
            SQ_LOAD: begin
               st <= SQ_WAIT;
               if (enter_full || idx == IDX_W'(STEPS - 1)) begin
                  idx <= '0;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_wr   = (st == SQ_WRITE);
      reg_load = (st == SQ_LOAD);
      reg_sel  = reg_wr ? bidx : '0;
      reg_data = '0;
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (reg_wr && bidx == SEL_W'(b)) begin
            reg_data = word_q[b*BYTE_W +: BYTE_W];
         end
      end
   end

   assign running = (st != SQ_IDLE);

   rail_byte_bank #(
      .NUM_BYTES (NUM_BYTES),
      .BYTE_W    (BYTE_W),
      .SEL_W     (SEL_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .sel   (reg_sel),
      .data  (reg_data),
      .load  (reg_load),
      .lines (rail_lines)
   );

   assert_sel_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (reg_sel < SEL_W'(NUM_BYTES)));

   assert_wr_order_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel != SEL_W'(NUM_BYTES - 1) && !start) |=> (reg_wr && reg_sel == $past(reg_sel) + SEL_W'(1)));

   assert_load_after_last_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_W'(NUM_BYTES - 1) && !start) |=> reg_load);

   assert_load_single_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      reg_load |=> !reg_load);

   assert_idle_quiet_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!reg_wr && !reg_load));

   assert_no_accept_busy_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_load && !start) |=> !reg_wr);

endmodule

// File: tb/sim_rail_step_seq.sv
module sim_rail_step_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        step_en = 1'b0;
   logic [15:0] warmup_cycles = '0;
   logic [1:0]  reg_sel;
   logic [7:0]  reg_data;
   logic        reg_wr;
   logic        reg_load;
   logic [23:0] rail_lines;
   logic        running;
   logic        full_op;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rail_step_seq u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .step_en       (step_en),
      .warmup_cycles (warmup_cycles),
      .reg_sel       (reg_sel),
      .reg_data      (reg_data),
      .reg_wr        (reg_wr),
      .reg_load      (reg_load),
      .rail_lines    (rail_lines),
      .running       (running),
      .full_op       (full_op)
   );

   // reference model state
   int          q[$];
   bit          m_run = 0;
   bit          m_full = 0;
   int          m_idx = 0;
   int          m_cnt = 0;
   int          m_tgt = 0;
   logic [23:0] m_word = '0;
   logic [23:0] m_lines = '0;
   bit          m_live = 0;

   function automatic logic [23:0] pattern(bit fullset, int k);
      logic [23:0] w;
      w = 24'(1) << k;                  // R6 forward line k
      if (fullset) w |= 24'(1) << (23 - k); // R7 mirrored reverse line
      return w;
   endfunction

   always @(posedge clk) begin
      m_live = 1;
      if (!rst_n) begin
         q.delete();
         m_run = 0; m_full = 0; m_idx = 0; m_cnt = 0; m_tgt = 0;
         m_word = '0; m_lines = '0;
      end else if (start) begin
         // R10: a load in flight still completes
         if (q.size() > 0 && q[0] == 3) m_lines = m_word;
         q.delete();
         m_run = 1; m_idx = 0; m_cnt = 0;
         m_tgt = int'(warmup_cycles);
         m_full = (m_tgt == 0);
      end else if (m_run) begin
         if (q.size() > 0) begin
            int ev;
            ev = q.pop_front();
            if (ev == 3) begin
               m_lines = m_word;
               m_idx = (m_idx + 1) % 12;  // R9 wrap
               if (!m_full) begin
                  m_cnt++;
                  if (m_cnt == m_tgt) begin
                     m_full = 1;
                     m_idx = 0;
                  end
               end
            end
         end else if (step_en) begin
            m_word = pattern(m_full, m_idx);
            q = '{0, 1, 2, 3};
         end
      end
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_live && !done) begin
         bit          e_wr, e_ld;
         logic [1:0]  e_sel;
         logic [7:0]  e_dat;
         e_wr  = (q.size() > 0) && (q[0] < 3);
         e_ld  = (q.size() > 0) && (q[0] == 3);
         e_sel = e_wr ? 2'(q[0]) : 2'd0;
         e_dat = e_wr ? 8'(m_word >> (8 * q[0])) : 8'd0;
         check("R3", "reg_wr", 32'(reg_wr), 32'(e_wr));
         check("R3", "reg_sel", 32'(reg_sel), 32'(e_sel));
         check("R3", "reg_data", 32'(reg_data), 32'(e_dat));
         check("R4", "reg_load", 32'(reg_load), 32'(e_ld));
         check("R4 R6 R7 R9", "rail_lines", 32'(rail_lines), 32'(m_lines));
         check("R8", "full_op", 32'(full_op), 32'(m_full));
         check("R1 R2", "running", 32'(running), 32'(m_run));
      end
   end

   int lfsr = 32'h1ACE;

   task automatic cycles(int n, int mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
         case (mode)
            0: step_en = 1'b0;
            1: step_en = 1'b1;              // R5 collisions with busy cycles
            default: step_en = lfsr[0] ^ lfsr[3];
         endcase
      end
   endtask

   task automatic pulse_start(int w);
      @(negedge clk);
      warmup_cycles = 16'(w);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      // R1 reset state, then R2 step_en before any start
      cycles(3, 1);
      @(negedge clk) rst_n = 1'b1;
      cycles(20, 1);
      // R8 R9: warm-up longer than the index range, steps back to back
      pulse_start(14);
      cycles(400, 1);
      // random request pattern
      cycles(300, 2);
      // R10: restart inside a write sequence, W = 0 (R8)
      pulse_start(2);
      cycles(7, 1);
      pulse_start(0);
      cycles(200, 2);
      // R10: restart timed onto various cycles of a sequence
      for (int k = 0; k < 6; k++) begin
         pulse_start(1);
         cycles(k + 3, 1);
      end
      pulse_start(3);
      cycles(150, 1);
      cycles(10, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule